// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is a synthesizable model of the command state machine inside a two-bank NOR flash device. It connects to a simple bus that has a write strobe, a read strobe, an address and a data word. It decodes multi-write command sequences for a standard program, unlock-bypass entry, bypass program, bypass exit, autoselect (ID read) entry and read/reset. A program operation is applied to a small register-based array. Each program is followed by a fixed busy period, and during that period every incoming write is ignored.

The address MSB (bit 11 with the default parameters) selects the bank. Bits 10:0 are the in-bank offset that command decoding compares against. The low `WORD_BITS` bits (bits 3:0 by default) index the word inside a bank. Command bytes are taken from `wdata[7:0]`. A read returns either array data or an ID code, and the value appears on the clock edge that follows the read strobe. The array reset value is the erased pattern of all ones.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `busy` is 0, `rdata` is 0, the decoder and autoselect are idle, and every array word reads FFFFh.
- R2: A standard program is four writes: AAh at offset 555h, 55h at offset 2AAh, A0h at offset 555h, then the target address and data. The target address may be any word in either bank.
- R3: A program stores the old word AND the new data, so a program operation can only clear bits.
- R4: `busy` rises on the edge that accepts the program data write and stays high for exactly `BUSY_CYCLES` cycles. The array word is updated on the edge where `busy` falls.
- R5: While `busy` is high, a read of the bank being programmed returns the stored word with bit 7 replaced by the complement of the target data's bit 7. A read of the other bank returns normal array data.
- R6: Every write accepted while `busy` is high is ignored, including the start of a new command sequence.
- R7: AAh@555h, 55h@2AAh, 20h@555h enter bypass mode. In bypass mode, A0h at any address followed by an address/data write programs the array. F0h has no effect in bypass mode.
- R8: In bypass mode, 90h followed by 00h (any addresses) leaves bypass mode. After that, a lone A0h write no longer starts a program.
- R9: AAh@555h, 55h@2AAh, 90h@555h enter autoselect and latch the bank from the address MSB. Only that bank returns IDs: offset 00h gives the manufacturer code, and offsets 01h, 0Eh and 0Fh give the three device-ID bytes in that order. The other bank returns array data.
- R10: The ID words are 0001h, 00FEh, 00A1h and 0080h. The low byte of each has odd parity, with bit 7 as the parity bit. Any other offset in the autoselected bank reads 0000h.
- R11: In autoselect mode, F0h written at any address returns reads to array data. All other writes are ignored until then.
- R12: A write that does not match the next step of a standard sequence returns the decoder to idle, so the rest of that sequence has no effect.
- R13: A reset during the busy period clears `busy` on that edge and discards the pending program.
- R14: `rdata` changes only on the edge that samples `rd_en` high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 12 | Bank bit in the MSB, in-bank offset below |
| wdata | input | 16 | Write data, command byte in bits 7:0 |
| rdata | output | 16 | Registered read data |
| busy | output | 1 | Embedded program in progress |

## Verification
Read data is due one cycle after the read strobe. `busy` is due on the edge that takes the program data write and remains high for `BUSY_CYCLES` cycles. The new array contents are visible to any read issued after `busy` falls. The bench drives every input on a falling edge and checks results on the next falling edge, so each check lands half a cycle after the edge that produced it. A behavioural busy-period model, fed by the bench's knowledge of which write should start a program, is compared with `busy` on every clock.

// File: rtl/flash_cmd_pkg.sv
// Package: shared command codes, sequence state type and ID-code helper
// for the flash command interpreter. Assumes command bytes sit in data[7:0].
package flash_cmd_pkg;

    localparam logic [7:0]  CMD_UNLOCK_1 = 8'hAA;
    localparam logic [7:0]  CMD_UNLOCK_2 = 8'h55;
    localparam logic [7:0]  CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0]  CMD_BYPASS   = 8'h20;
    localparam logic [7:0]  CMD_IDENTIFY = 8'h90;
    localparam logic [7:0]  CMD_RESET    = 8'hF0;
    localparam logic [7:0]  CMD_LEAVE    = 8'h00;
    localparam logic [11:0] OFS_UNLOCK_1 = 12'h555;
    localparam logic [11:0] OFS_UNLOCK_2 = 12'h2AA;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_GOT_1,
        SEQ_GOT_2,
        SEQ_WAIT_DATA,
        BYP_IDLE,
        BYP_WAIT_DATA,
        BYP_WAIT_LEAVE
    } seq_state_e;

    // Builds an ID byte: payload in bits 6:0, bit 7 makes the byte odd parity.
    function automatic logic [7:0] id_byte(input logic [6:0] payload);
        return {~(^payload), payload};
    endfunction

endpackage

// File: rtl/flash_seq_decoder.sv
// Module: flash_seq_decoder
// Decodes multi-write command sequences (standard program, bypass entry,
// bypass program, bypass exit, autoselect entry, read/reset) and issues a
// one-cycle program request. Assumes one write per cycle; writes seen while
// busy is high are dropped without any state change.
module flash_seq_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic              prog_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              as_active,
    output logic              as_bank
);

    localparam int OFS_W = ADDR_W - 1;

    seq_state_e       state_q, state_d;
    logic             as_active_d, as_bank_d;
    logic             start_d;
    logic [OFS_W-1:0] ofs;
    logic [7:0]       cmd;
    logic             at_first, at_second, accept;

    assign ofs       = addr[OFS_W-1:0];
    assign cmd       = wdata[7:0];
    assign at_first  = (ofs == OFS_W'(OFS_UNLOCK_1));
    assign at_second = (ofs == OFS_W'(OFS_UNLOCK_2));
    assign accept    = wr_en && !busy;

    // Next-state decode of the command sequence for one accepted write.
    always_comb begin
        state_d     = state_q;
        as_active_d = as_active;
        as_bank_d   = as_bank;
        start_d     = 1'b0;
        if (accept) begin
            if (as_active) begin
                if (cmd == CMD_RESET) as_active_d = 1'b0;
            end else begin
                unique case (state_q)
                    SEQ_IDLE: begin
                        if (cmd == CMD_UNLOCK_1 && at_first) state_d = SEQ_GOT_1;
                    end
                    SEQ_GOT_1: begin
                        state_d = (cmd == CMD_UNLOCK_2 && at_second) ? SEQ_GOT_2 : SEQ_IDLE;
                    end
                    SEQ_GOT_2: begin
                        state_d = SEQ_IDLE;
                        if (at_first && cmd == CMD_PROGRAM) begin
                            state_d = SEQ_WAIT_DATA;
                        end else if (at_first && cmd == CMD_BYPASS) begin
                            state_d = BYP_IDLE;
                        end else if (at_first && cmd == CMD_IDENTIFY) begin
                            as_active_d = 1'b1;
                            as_bank_d   = addr[ADDR_W-1];
                        end
                    end
                    SEQ_WAIT_DATA: begin
                        start_d = 1'b1;
                        state_d = SEQ_IDLE;
                    end
                    BYP_IDLE: begin
                        if (cmd == CMD_PROGRAM)       state_d = BYP_WAIT_DATA;
                        else if (cmd == CMD_IDENTIFY) state_d = BYP_WAIT_LEAVE;
                    end
                    BYP_WAIT_DATA: begin
                        start_d = 1'b1;
                        state_d = BYP_IDLE;
                    end
                    BYP_WAIT_LEAVE: begin
                        state_d = (cmd == CMD_LEAVE) ? SEQ_IDLE : BYP_IDLE;
                    end
                    default: state_d = SEQ_IDLE;
                endcase
            end
        end
    end

    // Registers the sequence state and the latched autoselect bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            as_active <= 1'b0;
            as_bank   <= 1'b0;
        end else begin
            state_q   <= state_d;
            as_active <= as_active_d;
            as_bank   <= as_bank_d;
        end
    end

    assign prog_start = start_d;
    assign prog_addr  = addr;
    assign prog_data  = wdata;

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> ($stable(state_q) && $stable(as_active))); // R6
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !busy); // R6
    AST_BYPASS_EXCLUDES_ID: assert property (@(posedge clk) disable iff (!rst_n)
        as_active |-> (state_q == SEQ_IDLE)); // R7

endmodule

// File: rtl/flash_prog_timer.sv
// Module: flash_prog_timer
// Holds the pending program target and counts the busy period. The commit
// pulse is high in the final busy cycle; the array writes on that edge.
// Assumes start is never raised while busy.
module flash_prog_timer #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 16,
    parameter int BUSY_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              busy,
    output logic              commit,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [DATA_W-1:0] pend_data
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    assign busy   = (cnt_q != '0);
    assign commit = (cnt_q == CNT_W'(1));

    // Loads the busy counter on a request and counts it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(BUSY_CYCLES);
        end else if (busy) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Captures the target word and data when a program is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_data <= '0;
        end else if (start) begin
            pend_addr <= addr_in;
            pend_data <= data_in;
        end
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R4
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> busy); // R4
    AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy); // R4

endmodule

// File: rtl/flash_bank_array.sv
// Module: flash_bank_array
// Register-based two-bank word array with the AND-only program rule and a
// registered read path that selects array data, status-polling data or ID
// codes. Assumes exactly two banks, chosen by the address MSB.
module flash_bank_array
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W         = 12,
    parameter int         DATA_W         = 16,
    parameter int         WORDS_PER_BANK = 16,
    parameter logic [6:0] MFR_PAYLOAD    = 7'h01,
    parameter logic [6:0] DEV0_PAYLOAD   = 7'h7E,
    parameter logic [6:0] DEV1_PAYLOAD   = 7'h21,
    parameter logic [6:0] DEV2_PAYLOAD   = 7'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              commit,
    input  logic              busy,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic [DATA_W-1:0] pend_data,
    input  logic              as_active,
    input  logic              as_bank,
    output logic [DATA_W-1:0] rdata
);

    localparam int WORD_BITS = $clog2(WORDS_PER_BANK);
    localparam int IDX_W     = WORD_BITS + 1;
    localparam int NUM_WORDS = 2 * WORDS_PER_BANK;
    localparam int PAD_W     = DATA_W - 8;

    logic [DATA_W-1:0] mem [NUM_WORDS];
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic              rd_bank;
    logic [DATA_W-1:0] rd_val;
    logic              id_hit, id_hit_q;

    assign rd_bank = addr[ADDR_W-1];
    assign rd_idx  = {rd_bank, addr[WORD_BITS-1:0]};
    assign wr_idx  = {pend_addr[ADDR_W-1], pend_addr[WORD_BITS-1:0]};

    // Storage: erased on reset, AND-merged with the pending data on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '1;
        end else if (commit) begin
            mem[wr_idx] <= mem[wr_idx] & pend_data;
        end
    end

    // Read source select: ID codes, polling bit 7, or plain array data.
    always_comb begin
        rd_val = mem[rd_idx];
        id_hit = 1'b0;
        if (as_active && rd_bank == as_bank) begin
            id_hit = 1'b1;
            unique case (addr[7:0])
                8'h00:   rd_val = {{PAD_W{1'b0}}, id_byte(MFR_PAYLOAD)};
                8'h01:   rd_val = {{PAD_W{1'b0}}, id_byte(DEV0_PAYLOAD)};
                8'h0E:   rd_val = {{PAD_W{1'b0}}, id_byte(DEV1_PAYLOAD)};
                8'h0F:   rd_val = {{PAD_W{1'b0}}, id_byte(DEV2_PAYLOAD)};
                default: begin
                    rd_val = '0;
                    id_hit = 1'b0;
                end
            endcase
        end else if (busy && rd_bank == pend_addr[ADDR_W-1]) begin
            rd_val[7] = ~pend_data[7];
        end
    end

    // Registered read port: updates only when a read is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            id_hit_q <= 1'b0;
        end else if (rd_en) begin
            rdata    <= rd_val;
            id_hit_q <= id_hit;
        end
    end

    AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        id_hit_q |-> (^rdata[7:0])); // R10
    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R14

endmodule

// File: rtl/flash_cmd_seq.sv
// Module: flash_cmd_seq (top)
// Two-bank NOR flash command interpreter: sequence decoder, program busy
// timer and word array. Assumes a single bus master issuing at most one
// write per cycle.
module flash_cmd_seq #(
    parameter int ADDR_W         = 12,
    parameter int DATA_W         = 16,
    parameter int WORDS_PER_BANK = 16,
    parameter int BUSY_CYCLES    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy
);

    logic              prog_start, commit, as_active, as_bank;
    logic [ADDR_W-1:0] req_addr, pend_addr;
    logic [DATA_W-1:0] req_data, pend_data;

    flash_seq_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) decoder_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .prog_start(prog_start), .prog_addr(req_addr),
        .prog_data(req_data), .as_active(as_active), .as_bank(as_bank)
    );

    flash_prog_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .addr_in(req_addr),
        .data_in(req_data), .busy(busy), .commit(commit),
        .pend_addr(pend_addr), .pend_data(pend_data)
    );

    flash_bank_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS_PER_BANK(WORDS_PER_BANK)) array_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .commit(commit),
        .busy(busy), .pend_addr(pend_addr), .pend_data(pend_data),
        .as_active(as_active), .as_bank(as_bank), .rdata(rdata)
    );

    AST_RESET_CLEARS_BUSY: assert property (@(posedge clk)
        !rst_n |=> !busy); // R13

endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;

    localparam int BUSY_CYCLES = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    bit  mark_prog = 0;
    int  m_cnt = 0;

    always #10 clk = ~clk;

    flash_cmd_seq #(.BUSY_CYCLES(BUSY_CYCLES)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    // Reference busy model: a program-data write starts a countdown.
    always @(posedge clk) begin
        if (!rst_n)                             m_cnt = 0;
        else if (m_cnt > 0)                     m_cnt = m_cnt - 1;
        else if (wr_en && mark_prog)            m_cnt = BUSY_CYCLES;
    end

    // Per-cycle comparison of busy against the model (R4).
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (busy !== (m_cnt != 0)) begin
                errors++;
                $display("FAIL R4 busy model: actual=%0b expected=%0b", busy, m_cnt != 0);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d, input bit prog = 0);
        wr_en = 1'b1; addr = a; wdata = d; mark_prog = prog;
        @(negedge clk);
        wr_en = 1'b0; mark_prog = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [15:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, rdata, exp);
    endtask

    task automatic unlock();
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 busy", {15'd0, busy}, 16'h0000);
        chk("R1 rdata", rdata, 16'h0000);
        rd(12'h000, 16'hFFFF, "R1 erased bank0");
        rd(12'h80F, 16'hFFFF, "R1 erased bank1");

        // R2 / R4: standard program with busy length check
        unlock();
        wr(12'h555, 16'h00A0);
        wr(12'h003, 16'h1234, 1);
        for (int i = 0; i < BUSY_CYCLES; i++) begin
            chk("R4 busy high", {15'd0, busy}, 16'h0001);
            @(negedge clk);
        end
        chk("R4 busy low", {15'd0, busy}, 16'h0000);
        rd(12'h003, 16'h1234, "R2 standard program");

        // R3: AND-only rule
        unlock(); wr(12'h555, 16'h00A0); wr(12'h003, 16'h0F0F, 1); wait_idle();
        rd(12'h003, 16'h0204, "R3 clear only");
        unlock(); wr(12'h555, 16'h00A0); wr(12'h003, 16'hFFFF, 1); wait_idle();
        rd(12'h003, 16'h0204, "R3 no set");

        // R5 / R6: polling read and ignored writes during busy (bank 1 target)
        unlock(); wr(12'h555, 16'h00A0); wr(12'h805, 16'h00AA, 1);
        rd(12'h805, 16'hFF7F, "R5 polling bit7");
        rd(12'h003, 16'h0204, "R5 other bank");
        unlock(); wr(12'h555, 16'h00A0);
        wait_idle();
        wr(12'h00A, 16'h0000);
        @(negedge clk);
        chk("R6 no program", {15'd0, busy}, 16'h0000);
        rd(12'h00A, 16'hFFFF, "R6 ignored sequence");
        rd(12'h805, 16'h00AA, "R5 true data");

        // R7: bypass mode
        unlock(); wr(12'h555, 16'h0020);
        wr(12'h100, 16'h00A0); wr(12'h007, 16'h5A5A, 1); wait_idle();
        rd(12'h007, 16'h5A5A, "R7 bypass program");
        wr(12'h000, 16'h00F0);
        wr(12'h000, 16'h00A0); wr(12'h008, 16'h1111, 1); wait_idle();
        rd(12'h008, 16'h1111, "R7 F0 ignored");

        // R8: bypass exit
        wr(12'h000, 16'h0090); wr(12'h000, 16'h0000);
        wr(12'h000, 16'h00A0); wr(12'h009, 16'h0000);
        @(negedge clk);
        chk("R8 no program", {15'd0, busy}, 16'h0000);
        rd(12'h009, 16'hFFFF, "R8 after exit");

        // R9 / R10: autoselect on bank 1
        unlock(); wr(12'hD55, 16'h0090);
        rd(12'h800, 16'h0001, "R9 mfr");
        chk("R10 parity mfr", {15'd0, ^rdata[7:0]}, 16'h0001);
        rd(12'h801, 16'h00FE, "R9 dev0");
        chk("R10 parity dev0", {15'd0, ^rdata[7:0]}, 16'h0001);
        rd(12'h80E, 16'h00A1, "R9 dev1");
        chk("R10 parity dev1", {15'd0, ^rdata[7:0]}, 16'h0001);
        rd(12'h80F, 16'h0080, "R9 dev2");
        chk("R10 parity dev2", {15'd0, ^rdata[7:0]}, 16'h0001);
        rd(12'h802, 16'h0000, "R10 other offset");
        rd(12'h003, 16'h0204, "R9 other bank");

        // R11: writes ignored in autoselect, F0 exits
        unlock(); wr(12'h555, 16'h00A0); wr(12'h00C, 16'h0000);
        @(negedge clk);
        chk("R11 no program", {15'd0, busy}, 16'h0000);
        wr(12'h3C4, 16'h00F0);
        rd(12'h801, 16'hFFFF, "R11 array after exit");
        rd(12'h805, 16'h00AA, "R11 array bank1");
        rd(12'h00C, 16'hFFFF, "R11 ignored program");

        // R12: mismatch returns to idle
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0011);
        wr(12'h555, 16'h00A0); wr(12'h00D, 16'h0000);
        @(negedge clk);
        chk("R12 no program", {15'd0, busy}, 16'h0000);
        rd(12'h00D, 16'hFFFF, "R12 mismatch");

        // R14: rdata holds without a read strobe
        rd(12'h007, 16'h5A5A, "R14 setup");
        addr = 12'h003;
        repeat (3) @(negedge clk);
        chk("R14 hold", rdata, 16'h5A5A);

        // R13: reset aborts a program
        unlock(); wr(12'h555, 16'h00A0); wr(12'h00E, 16'h0000, 1);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R13 busy cleared", {15'd0, busy}, 16'h0000);
        chk("R1 rdata after reset", rdata, 16'h0000);
        repeat (BUSY_CYCLES) @(negedge clk);
        rd(12'h00E, 16'hFFFF, "R13 program discarded");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule